// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Pending Latch

This block gathers level-sensitive interrupt lines, arranged in groups of 32, and produces one interrupt output per group. Firmware sees each group through two 32-bit registers on a simple memory-mapped port. The enable register selects which lines of the group may report. The status register shows which lines caused the group output to be raised.

When a group's lines go active, the enabled subset is captured. The group may already be reporting something, or firmware may have masked it. In either case the new bits are not lost: they collect in a hidden pending latch. That latch is moved into the status register once firmware has acknowledged every status bit.

The enable register has two roles. A write that adds new bits grows a sticky enable set. Any other write toggles mask bits, which firmware uses to hold off new deliveries while a handler runs.

Top module: `grp_irq_aggregator`

## Requirements
- R1: After reset, every enable set, register copy, mask, status and pending latch is zero, `irqOut` is all zero and `rdData` is zero.
- R2: Group n is reached at byte address 0x1000 + 0x100*n for its enable register and 0x1000 + 0x100*n + 4 for its status register. The group index is taken from address bits [11:8], and bit 12 must be set.
- R3: Reading an enable register returns the data last written to it, not the accumulated enable set.
- R4: A rising edge of the OR of a group's lines captures the lines ANDed with the enable set. If the mask and the status are both zero and the result is nonzero, the status takes the result and the group output rises on the clock edge that samples the line change. A zero result changes nothing.
- R5: If the captured vector is nonzero while the group's status is nonzero or its mask is nonzero, the vector is ORed into the pending latch. The status and the output are left unchanged.
- R6: An enable write ORs its data into the enable set. If that adds bits, only the register copy is also updated and the mask is untouched. A write of zero while the enable set is zero only stores zero in the copy.
- R7: An enable write that adds no bits computes change = copy XOR data. If change AND data is nonzero, the change bits are cleared from the mask. Otherwise they are set in the mask. The copy then takes the data.
- R8: Status writes clear the bits that are one in the data. If the status is then zero, two cases follow. When the pending latch is nonzero, it moves into the status, the latch clears and the output stays high. When the latch is zero, the output falls.
- R9: A status write of all ones clears the status and takes no other action: the output level and the pending latch are kept.
- R10: Reads of any address other than a valid group's enable or status register return zero. Writes to such addresses change no state and no output.
- R11: When a capture and a status write reach the same group in the same cycle, the write is applied first and the capture sees its result.
- R12: Read data appears on `rdData` at the clock edge that samples `rdEn` and reflects state from before that edge. `rdData` is zero in cycles after no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLines | input | GROUPS*LINES | Synchronous source lines; group g uses bits [g*LINES +: LINES] |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the access |
| wrData | input | LINES | Write data |
| rdData | output | LINES | Registered read data |
| irqOut | output | GROUPS | One interrupt output per group |

## Verification
Each result of this block is due a fixed number of edges after the stimulus that causes it. A register write or a line change takes effect on the single edge that samples it. The group output therefore shows the result at the following falling edge. Read data is registered once, so it is due exactly one edge after `rdEn`. The scoreboard tags each expected item with its due cycle and compares it at the falling edge of that cycle. A same-cycle status write and capture are driven together, and the read-back shows which was applied first.

// File: rtl/grp_irq_pkg.sv
package grp_irq_pkg;

  typedef struct packed {
    logic enWr;
    logic stWr;
    logic capture;
  } grpStrobe_t;

  localparam logic [7:0] ENA_OFS = 8'h00;
  localparam logic [7:0] STS_OFS = 8'h04;

endpackage

// File: rtl/grp_irq_ctrl.sv
module grp_irq_ctrl
  import grp_irq_pkg::*;
#(
  parameter int GROUPS = 9,
  parameter int LINES  = 32,
  parameter int ADDR_W = 13
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [GROUPS*LINES-1:0]   srcLines,
  input  logic                      wrEn,
  input  logic                      rdEn,
  input  logic [ADDR_W-1:0]         addr,
  output grpStrobe_t                strobes [GROUPS],
  output logic                      rdHit,
  output logic                      rdStatus,
  output logic [3:0]                rdGroup
);

  localparam logic [4:0] GRP_LIM = 5'(GROUPS);

  logic [3:0]        grpIdx;
  logic              winHit;
  logic              isEn;
  logic              isSt;
  logic [GROUPS-1:0] anyNow;
  logic [GROUPS-1:0] anyPrev;

  assign grpIdx = addr[11:8];
  assign winHit = (addr[ADDR_W-1:12] == (ADDR_W-12)'(1)) && ({1'b0, grpIdx} < GRP_LIM);
  assign isEn   = winHit && (addr[7:0] == ENA_OFS);
  assign isSt   = winHit && (addr[7:0] == STS_OFS);

  assign rdHit    = rdEn && (isEn || isSt);
  assign rdStatus = isSt;
  assign rdGroup  = grpIdx;

  for (genvar g = 0; g < GROUPS; g++) begin : gStrobe
    assign anyNow[g]          = |srcLines[g*LINES +: LINES];
    assign strobes[g].enWr    = wrEn && isEn && (grpIdx == 4'(g));
    assign strobes[g].stWr    = wrEn && isSt && (grpIdx == 4'(g));
    assign strobes[g].capture = anyNow[g] && !anyPrev[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN) anyPrev <= '0;
    else       anyPrev <= anyNow;
  end

endmodule

// File: rtl/grp_irq_datapath.sv
module grp_irq_datapath
  import grp_irq_pkg::*;
#(
  parameter int GROUPS = 9,
  parameter int LINES  = 32
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  grpStrobe_t              strobes [GROUPS],
  input  logic [GROUPS*LINES-1:0] srcLines,
  input  logic [LINES-1:0]        wrData,
  input  logic                    rdHit,
  input  logic                    rdStatus,
  input  logic [3:0]              rdGroup,
  output logic [LINES-1:0]        rdData,
  output logic [GROUPS-1:0]       irqOut
);

  logic [LINES-1:0] stsArr [GROUPS];
  logic [LINES-1:0] cpyArr [GROUPS];

  for (genvar g = 0; g < GROUPS; g++) begin : gGrp
    logic [LINES-1:0] enSet, enCopy, maskReg, statusReg, pendReg;
    logic [LINES-1:0] enN, cpN, mkN, stN, pdN, chg, sel, srcGrp;
    logic             irqReg, irN;
    grpStrobe_t       stb;

    assign stb    = strobes[g];
    assign srcGrp = srcLines[g*LINES +: LINES];

    always_comb begin
      enN = enSet;  cpN = enCopy;    mkN = maskReg;
      stN = statusReg; pdN = pendReg; irN = irqReg;
      chg = '0;     sel = '0;
      // enable register: grow the sticky set, or toggle mask bits
      if (stb.enWr) begin
        if (wrData == '0 && enSet == '0) begin
          cpN = wrData;
        end else if ((enSet | wrData) != enSet) begin
          enN = enSet | wrData;
          cpN = wrData;
        end else begin
          chg = enCopy ^ wrData;
          if ((chg & wrData) != '0) mkN = maskReg & ~chg;
          else                      mkN = maskReg | chg;
          cpN = wrData;
        end
      end
      // status register: write-one-to-clear, then hand over pending bits
      if (stb.stWr) begin
        stN = statusReg & ~wrData;
        if (wrData != '1 && stN == '0) begin
          if (pendReg != '0) begin
            stN = pendReg;
            pdN = '0;
            irN = 1'b1;
          end else begin
            irN = 1'b0;
          end
        end
      end
      // capture sees the state after any same-cycle write
      if (stb.capture) begin
        sel = srcGrp & enN;
        if (sel != '0) begin
          if (mkN != '0 || stN != '0) begin
            pdN = pdN | sel;
          end else begin
            stN = sel;
            irN = 1'b1;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        enSet <= '0; enCopy <= '0; maskReg <= '0;
        statusReg <= '0; pendReg <= '0; irqReg <= 1'b0;
      end else begin
        enSet <= enN; enCopy <= cpN; maskReg <= mkN;
        statusReg <= stN; pendReg <= pdN; irqReg <= irN;
      end
    end

    assign stsArr[g]  = statusReg;
    assign cpyArr[g]  = enCopy;
    assign irqOut[g]  = irqReg;
  end

  logic [LINES-1:0] rdVal;

  always_comb begin
    rdVal = '0;
    for (int g = 0; g < GROUPS; g++) begin
      if (rdGroup == 4'(g)) rdVal = rdStatus ? stsArr[g] : cpyArr[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      rdData <= '0;
    else if (rdHit) rdData <= rdVal;
    else            rdData <= '0;
  end

endmodule

// File: rtl/grp_irq_aggregator.sv
module grp_irq_aggregator
  import grp_irq_pkg::*;
#(
  parameter int GROUPS = 9,
  parameter int LINES  = 32,
  parameter int ADDR_W = 13
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [GROUPS*LINES-1:0] srcLines,
  input  logic                    wrEn,
  input  logic                    rdEn,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LINES-1:0]        wrData,
  output logic [LINES-1:0]        rdData,
  output logic [GROUPS-1:0]       irqOut
);

  grpStrobe_t strobes [GROUPS];
  logic       rdHit;
  logic       rdStatus;
  logic [3:0] rdGroup;

  grp_irq_ctrl #(.GROUPS(GROUPS), .LINES(LINES), .ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .strobes(strobes), .rdHit(rdHit), .rdStatus(rdStatus),
    .rdGroup(rdGroup)
  );

  grp_irq_datapath #(.GROUPS(GROUPS), .LINES(LINES)) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes), .srcLines(srcLines),
    .wrData(wrData), .rdHit(rdHit), .rdStatus(rdStatus), .rdGroup(rdGroup),
    .rdData(rdData), .irqOut(irqOut)
  );

endmodule

// File: rtl/grp_irq_aggregator_chk.sv
module grp_irq_aggregator_chk #(
  parameter int GROUPS = 9,
  parameter int LINES  = 32,
  parameter int ADDR_W = 13
) (
  input logic                    clk,
  input logic                    rstN,
  input logic [GROUPS*LINES-1:0] srcLines,
  input logic                    wrEn,
  input logic                    rdEn,
  input logic [ADDR_W-1:0]       addr,
  input logic [LINES-1:0]        rdData,
  input logic [GROUPS-1:0]       irqOut
);

  logic [GROUPS-1:0] lineAny;
  logic [GROUPS-1:0] lineAnyQ;
  logic              oobRead;

  assign oobRead = rdEn && ({1'b0, addr[11:8]} >= 5'(GROUPS));

  always_ff @(posedge clk) begin
    if (!rstN) lineAnyQ <= '0;
    else       lineAnyQ <= lineAny;
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $rose(rstN) |-> (irqOut == '0 && rdData == '0));

  a_r12_idle_zero: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> rdData == '0);

  a_r10_oob_read: assert property (@(posedge clk) disable iff (!rstN)
    $past(oobRead) |-> rdData == '0);

  for (genvar g = 0; g < GROUPS; g++) begin : gChk
    assign lineAny[g] = |srcLines[g*LINES +: LINES];

    a_r4_rise_cause: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqOut[g]) |-> $past(wrEn || (lineAny[g] && !lineAnyQ[g])));

    a_r8_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irqOut[g]) |-> $past(wrEn));
  end

endmodule

bind grp_irq_aggregator grp_irq_aggregator_chk #(
  .GROUPS(GROUPS), .LINES(LINES), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rstN(rstN), .srcLines(srcLines), .wrEn(wrEn), .rdEn(rdEn),
  .addr(addr), .rdData(rdData), .irqOut(irqOut)
);

// File: tb/grp_irq_aggregator_tb_top.sv
module grp_irq_aggregator_tb_top;

  localparam int GROUPS = 9;
  localparam int LINES  = 32;
  localparam int ADDR_W = 13;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic [GROUPS*LINES-1:0] srcLines = '0;
  logic                    wrEn = 1'b0;
  logic                    rdEn = 1'b0;
  logic [ADDR_W-1:0]       addr = '0;
  logic [LINES-1:0]        wrData = '0;
  logic [LINES-1:0]        rdData;
  logic [GROUPS-1:0]       irqOut;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  typedef struct {
    int          due;
    bit          isIrq;
    logic [31:0] val;
    string       req;
  } expItem_t;

  expItem_t sbQ[$];

  grp_irq_aggregator #(.GROUPS(GROUPS), .LINES(LINES), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .srcLines(srcLines), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  always #5 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every item whose due cycle has come
  always @(negedge clk) begin
    while (sbQ.size() > 0 && sbQ[0].due <= cyc) begin
      expItem_t it;
      logic [31:0] act;
      it = sbQ.pop_front();
      act = it.isIrq ? 32'(irqOut) : 32'(rdData);
      checks++;
      if (act !== it.val) begin
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", it.req,
                 it.isIrq ? "irqOut" : "rdData", act, it.val);
      end
    end
  end

  task automatic wr(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input logic [ADDR_W-1:0] a, input logic [31:0] e, input string req);
    expItem_t it;
    rdEn = 1'b1; addr = a;
    it.due = cyc + 1; it.isIrq = 1'b0; it.val = e; it.req = req;
    sbQ.push_back(it);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic setSrc(input int g, input logic [31:0] v);
    srcLines[g*LINES +: LINES] = v;
    @(negedge clk);
  endtask

  task automatic expIrq(input logic [GROUPS-1:0] e, input string req);
    expItem_t it;
    it.due = cyc + 1; it.isIrq = 1'b1; it.val = 32'(e); it.req = req;
    sbQ.push_back(it);
    @(negedge clk);
  endtask

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rd(13'h1000, 32'h0, "R1");
    rd(13'h1004, 32'h0, "R1");
    expIrq('0, "R1");
    // R3 enable copy readback
    wr(13'h1000, 32'h0000_000F);
    rd(13'h1000, 32'h0000_000F, "R3");
    // R4 capture lines AND enable
    setSrc(0, 32'h0000_0011);
    expIrq(9'h001, "R4");
    rd(13'h1004, 32'h0000_0001, "R4");
    // R5 arrival while status nonzero goes pending
    setSrc(0, 32'h0);
    setSrc(0, 32'h0000_0002);
    rd(13'h1004, 32'h0000_0001, "R5");
    // R8 acknowledge delivers pending, output kept
    wr(13'h1004, 32'h0000_0001);
    expIrq(9'h001, "R8");
    rd(13'h1004, 32'h0000_0002, "R8");
    wr(13'h1004, 32'h0000_0002);
    expIrq(9'h000, "R8");
    rd(13'h1004, 32'h0, "R8");
    // R4 no enabled line -> nothing
    setSrc(0, 32'h0);
    setSrc(0, 32'h0000_0100);
    expIrq(9'h000, "R4");
    rd(13'h1004, 32'h0, "R4");
    // R7 mask via same-set enable write
    wr(13'h1000, 32'h0000_000E);
    setSrc(0, 32'h0);
    setSrc(0, 32'h0000_0004);
    expIrq(9'h000, "R7");
    rd(13'h1004, 32'h0, "R7");
    rd(13'h1000, 32'h0000_000E, "R7");
    wr(13'h1000, 32'h0000_000F);
    expIrq(9'h000, "R7");
    wr(13'h1004, 32'h0);
    expIrq(9'h001, "R7");
    rd(13'h1004, 32'h0000_0004, "R7");
    // R9 all-ones clears only
    wr(13'h1004, 32'hFFFF_FFFF);
    expIrq(9'h001, "R9");
    rd(13'h1004, 32'h0, "R9");
    wr(13'h1004, 32'h0);
    expIrq(9'h000, "R8");
    // R6 sticky enable growth
    wr(13'h1000, 32'h0000_0030);
    rd(13'h1000, 32'h0000_0030, "R6");
    setSrc(0, 32'h0);
    setSrc(0, 32'h0000_0001);
    rd(13'h1004, 32'h0000_0001, "R6");
    wr(13'h1004, 32'h0000_0001);
    expIrq(9'h000, "R6");
    wr(13'h1200, 32'h0);
    rd(13'h1200, 32'h0, "R6");
    // R2 last group address decode
    wr(13'h1800, 32'h8000_0000);
    setSrc(8, 32'h8000_0000);
    expIrq(9'h100, "R2");
    rd(13'h1804, 32'h8000_0000, "R2");
    // R10 out-of-range accesses
    wr(13'h1900, 32'h0000_00FF);
    wr(13'h1904, 32'hFFFF_FFFF);
    rd(13'h1900, 32'h0, "R10");
    rd(13'h1008, 32'h0, "R10");
    rd(13'h0800, 32'h0, "R10");
    expIrq(9'h100, "R10");
    rd(13'h1804, 32'h8000_0000, "R10");
    // R11 same-cycle write and capture: write first
    setSrc(8, 32'h0);
    wr(13'h1800, 32'h0000_0001);
    wrEn = 1'b1; addr = 13'h1804; wrData = 32'hFFFF_FFFF;
    srcLines[8*LINES +: LINES] = 32'h0000_0001;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    rd(13'h1804, 32'h0000_0001, "R11");  // also R12 one-cycle read latency
    expIrq(9'h100, "R11");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule